// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses that a memory controller drives during one read or write burst. A start command supplies the first column, a burst-length code, an ordering flag (linear or interleaved) and a write flag. From the next clock edge on, the block presents one column per beat, together with a valid flag and a flag that marks the final beat.

Fixed-length bursts wrap inside their own aligned block. Interleaved bursts flip the low column bits by the beat number. A full-page burst climbs through the 256 columns of the row, wraps from the top column to column 0, and keeps going until a stop request or a new command arrives. A suspend input freezes the sequence for as long as the clock is held. A single-location write mode limits every write command to one beat.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: The column address is COL_W bits wide, 8 by default. On the edge after a start command is sampled, `colValid` goes high and `colOut` equals `startCol` (beat 0).
- R2: With `interleave` low and a fixed length L, beat k carries the upper bits of the start column unchanged. Its low log2(L) bits equal (start + k) mod L, so the address wraps inside the aligned block.
- R3: With `interleave` high and a fixed length L, beat k equals the start column with its low log2(L) bits XORed by k.
- R4: Length codes on `lenCode`: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page. The unused codes 3'b100 to 3'b110 act as 1 beat.
- R5: A full-page burst gives (start + k) mod 2^COL_W on beat k whatever `interleave` is set to, and runs until a stop or a new start.
- R6: `lastBeat` is high exactly on the final beat of a fixed-length burst and is never high during a full-page burst. Once that beat advances, `colValid` is low on the next edge.
- R7: `burstStop` during a burst drives `colValid` low on the next edge, even while suspended.
- R8: A start command is taken on any cycle, including during a burst, and restarts the sequence at the new column. It takes priority over `burstStop` and `suspend`.
- R9: While `suspend` is high (and no stop or start is present), `colOut`, the beat position and `colValid` stay unchanged.
- R10: When `singleWrite` is high, a start with `isWrite` high produces exactly one beat, with `lastBeat` set, for any length code. Reads keep their programmed length.
- R11: After reset `colValid` and `lastBeat` are low and `colOut` is 0. `colOut` reads 0 whenever `colValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Read or write command, starts a burst |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | Burst-length code (see R4) |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| isWrite | input | 1 | The start command is a write |
| singleWrite | input | 1 | Writes are limited to a single location |
| suspend | input | 1 | Clock suspend, freezes the sequence |
| burstStop | input | 1 | Ends the running burst |
| colOut | output | COL_W | Current column address |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench builds the block with COL_W = 8. This keeps the row small enough to cover every start column under every length code and both orderings. Full-page runs are long enough to cross the wrap from column 255 to 0. The same width makes each expected address a short arithmetic expression, so the aligned-block wrap, the XOR ordering and the page wrap are each checked beat by beat. Targeted sequences then cover suspend, stop, interrupt and single-write priority.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_FULL = 3'b111
  } lenCode_e;

  typedef struct packed {
    logic load;
    logic advance;
  } burstStrobe_t;

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             isWrite,
  input  logic             singleWrite,
  input  logic             suspend,
  input  logic             burstStop,
  input  logic [COL_W-1:0] beat,
  output burstStrobe_t     strb,
  output logic [COL_W-1:0] maskQ,
  output logic             ilvQ,
  output logic             validQ,
  output logic             lastBeat
);

  localparam logic [COL_W-1:0] FULL_MASK = {COL_W{1'b1}};

  logic             fullQ;
  logic             atEnd;
  logic             validD;
  logic [COL_W-1:0] maskD;
  logic             fullD;
  logic             oneBeat;

  // decode of the mode applied at start
  always_comb begin
    oneBeat = isWrite && singleWrite;
    fullD   = 1'b0;
    maskD   = '0;
    if (!oneBeat) begin
      if (lenCode == LEN_FULL) begin
        fullD = 1'b1;
        maskD = FULL_MASK;
      end else if (!lenCode[2]) begin
        maskD = COL_W'((1 << lenCode[1:0]) - 1);
      end
    end
  end

  assign atEnd    = !fullQ && (beat == maskQ);
  assign lastBeat = validQ && atEnd;

  always_comb begin
    strb.load    = startReq;
    strb.advance = !startReq && validQ && !suspend && !burstStop && !atEnd;
    if (startReq)               validD = 1'b1;
    else if (burstStop)         validD = 1'b0;
    else if (validQ && suspend) validD = 1'b1;
    else                        validD = validQ && !atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      fullQ  <= 1'b0;
      maskQ  <= '0;
      ilvQ   <= 1'b0;
    end else begin
      validQ <= validD;
      if (startReq) begin
        fullQ <= fullD;
        maskQ <= maskD;
        ilvQ  <= interleave && !fullD;
      end
    end
  end

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStrobe_t     strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] maskQ,
  input  logic             ilvQ,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] linSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      beat    <= '0;
    end else if (strb.load) begin
      baseCol <= startCol;
      beat    <= '0;
    end else if (strb.advance) begin
      beat    <= beat + 1'b1;
    end
  end

  assign linSum = baseCol + beat;

  always_comb begin
    if (ilvQ) col = baseCol ^ (beat & maskQ);
    else      col = (baseCol & ~maskQ) | (linSum & maskQ);
  end

endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             isWrite,
  input  logic             singleWrite,
  input  logic             suspend,
  input  logic             burstStop,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);

  burstStrobe_t     strb;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;
  logic             validQ;
  logic [COL_W-1:0] dpCol;

  burst_addr_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lenCode(lenCode),
    .interleave(interleave), .isWrite(isWrite), .singleWrite(singleWrite),
    .suspend(suspend), .burstStop(burstStop), .beat(beat), .strb(strb),
    .maskQ(maskQ), .ilvQ(ilvQ), .validQ(validQ), .lastBeat(lastBeat)
  );

  burst_addr_dp #(.COL_W(COL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .maskQ(maskQ), .ilvQ(ilvQ), .beat(beat), .col(dpCol)
  );

  assign colValid = validQ;
  assign colOut   = validQ ? dpCol : '0;

endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       lenCode,
  input logic             isWrite,
  input logic             singleWrite,
  input logic             suspend,
  input logic             burstStop,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat
);

  logic modeFull;
  logic modeSingle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeFull   <= 1'b0;
      modeSingle <= 1'b0;
    end else if (startReq) begin
      modeSingle <= isWrite && singleWrite;
      modeFull   <= (lenCode == 3'b111) && !(isWrite && singleWrite);
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> colValid && colOut == $past(startCol)); // R1

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    colValid && suspend && !burstStop && !startReq |=> colValid && $stable(colOut)); // R9

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    colValid && burstStop && !startReq |=> !colValid); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && !suspend && !startReq |=> !colValid); // R6

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    colValid && modeFull |-> !lastBeat); // R6

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    colValid && modeFull && !suspend && !burstStop && !startReq
      |=> colOut == COL_W'($past(colOut) + 1'b1)); // R5

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    colValid && modeSingle |-> lastBeat); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> colOut == '0 && !lastBeat); // R11

endmodule

bind sdram_burst_addr_gen burst_addr_checker #(.COL_W(COL_W)) i_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .startCol(startCol),
  .lenCode(lenCode), .isWrite(isWrite), .singleWrite(singleWrite),
  .suspend(suspend), .burstStop(burstStop), .colOut(colOut),
  .colValid(colValid), .lastBeat(lastBeat)
);

// File: tb/test_sdram_burst_addr_gen.sv
module test_sdram_burst_addr_gen;

  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = 3'b000;
  logic             interleave = 1'b0;
  logic             isWrite = 1'b0;
  logic             singleWrite = 1'b0;
  logic             suspend = 1'b0;
  logic             burstStop = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid;
  logic             lastBeat;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sdram_burst_addr_gen #(.COL_W(COL_W)) i_sdram_burst_addr_gen (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .isWrite(isWrite),
    .singleWrite(singleWrite), .suspend(suspend), .burstStop(burstStop),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lenOf(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return PAGE;
      default: return 1;
    endcase
  endfunction

  function automatic int expCol(input int st, input int len, input bit ilv, input int k);
    if (len == PAGE) return (st + k) % PAGE;
    if (ilv) return st ^ (k % len);
    return (st - (st % len)) + ((st + k) % len);
  endfunction

  task automatic issue(input int st, input int code, input bit ilv, input bit wr, input bit sw);
    startReq = 1'b1; startCol = COL_W'(st); lenCode = 3'(code);
    interleave = ilv; isWrite = wr; singleWrite = sw;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Runs one burst; for full page, beats given by fullBeats then stopped.
  task automatic runBurst(input int st, input int code, input bit ilv,
                          input bit wr, input bit sw, input int fullBeats, input string req);
    int len;
    int n;
    len = (wr && sw) ? 1 : lenOf(code);
    n   = (len == PAGE) ? fullBeats : len;
    issue(st, code, ilv, wr, sw);
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, int'(colValid), 1);
      chk({req, " col"}, int'(colOut), expCol(st, len, ilv, k));
      chk({req, " R6 last"}, int'(lastBeat), (len != PAGE && k == n - 1) ? 1 : 0);
      if (len == PAGE && k == n - 1) burstStop = 1'b1;
      @(negedge clk);
      burstStop = 1'b0;
    end
    chk({req, " end valid"}, int'(colValid), 0);
    chk({req, " R11 idle col"}, int'(colOut), 0);
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset valid", int'(colValid), 0);
    chk("R11 reset last", int'(lastBeat), 0);
    chk("R11 reset col", int'(colOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 sweep: every start column, length and ordering
    for (int code = 0; code < 8; code++) begin
      if (code >= 4 && code <= 6) continue;
      for (int ilv = 0; ilv < 2; ilv++)
        for (int st = 0; st < PAGE; st++)
          runBurst(st, code, ilv[0], st[0], 1'b0, (st % 5 == 0) ? 260 : 6,
                   code == 7 ? "R5 full" : (ilv != 0 ? "R3 ilv" : "R2 seq"));
    end

    // R4 unused codes behave as one beat
    for (int code = 4; code < 7; code++) runBurst(37, code, 1'b0, 1'b0, 1'b0, 1, "R4 unused");

    // R10 single-write: writes one beat, reads keep length
    runBurst(19, 3, 1'b0, 1'b1, 1'b1, 1, "R10 write");
    runBurst(250, 7, 1'b0, 1'b1, 1'b1, 1, "R10 full write");
    runBurst(19, 3, 1'b1, 1'b0, 1'b1, 1, "R10 read");

    // R9 suspend freezes
    issue(10, 7, 1'b0, 1'b0, 1'b0);
    chk("R9 pre col", int'(colOut), 10);
    suspend = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 frozen col", int'(colOut), 10);
      chk("R9 frozen valid", int'(colValid), 1);
    end
    suspend = 1'b0;
    @(negedge clk);
    chk("R9 resume col", int'(colOut), 11);

    // R7 stop under suspend
    suspend = 1'b1; burstStop = 1'b1;
    @(negedge clk);
    suspend = 1'b0; burstStop = 1'b0;
    chk("R7 stop valid", int'(colValid), 0);

    // R9 suspend on last beat of fixed burst holds it
    issue(6, 0, 1'b0, 1'b0, 1'b0);
    suspend = 1'b1;
    @(negedge clk);
    chk("R9 hold last", int'(lastBeat), 1);
    chk("R9 hold col", int'(colOut), 6);
    suspend = 1'b0;
    @(negedge clk);
    chk("R6 drop after last", int'(colValid), 0);

    // R8 interrupt mid-burst, start beats stop and suspend
    issue(5, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 pre col", int'(colOut), 6);
    burstStop = 1'b1; suspend = 1'b1;
    issue(200, 2, 1'b1, 1'b0, 1'b0);
    burstStop = 1'b0; suspend = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R8 restart col", int'(colOut), 200 ^ k);
      chk("R8 restart last", int'(lastBeat), k == 3 ? 1 : 0);
      @(negedge clk);
    end
    chk("R8 end valid", int'(colValid), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    done = 1'b1;
    $finish;
  end

endmodule